// File: doc/BRIEF.md
# Row-Page Pixel Frame Loader

This block holds a 64 by 64 array of binary pixel cells, with one storage bit per element. It also contains the controller that fills the array from a byte stream. Bytes arrive on a valid/ready handshake in row-major order and are written one per clock. Each row has a row-select (word) line, and a cell can only be written while that line is high.

The controller works in row-page fashion. It raises a row's line once and keeps it high for all eight byte writes of that row. It then drops the line, and during that single dead cycle the stream is stalled. Every stored bit is driven straight onto its pixel output, and the whole array is visible as a 4096-bit vector. When the last byte of a frame has been stored, a one-cycle done pulse is produced. A start pulse abandons a partial frame and begins again at the first byte.

Top module: `pixel_page_writer`

## Requirements
- R1: While reset is low, all word lines, `in_ready` and `frame_done` are low. After reset is released, `in_ready` stays low for one cycle, and the first accepted byte goes to row 0, byte 0.
- R2: Frame bytes are stored in row-major order. Accepted byte number k (0..511) goes to row k/8, byte lane k%8, and its bit b lands on `pixels[(k/8)*64 + (k%8)*8 + b]`, which is column (k%8)*8+b.
- R3: A byte is taken only in a cycle where `in_valid` and `in_ready` are both high, and at most one byte is taken per cycle. Cycles with `in_valid` low store nothing and do not move the write position.
- R4: At most one word line is high at a time. While `in_ready` is high, the line of the row that holds the next byte is high. That line stays high without a break across all eight writes of its row.
- R5: After the eighth byte of a row, there is exactly one cycle in which `in_ready` is low and all word lines are low. After that cycle, the next row's line is raised.
- R6: A cell's value changes only at a clock edge where its row's word line was high. All other cells, including those of rows not yet reached in a partial frame, keep their values.
- R7: `frame_done` is high for exactly the one cycle that follows the acceptance of the 512th byte. The next accepted byte is again row 0, byte 0.
- R8: A `frame_start` pulse takes no byte in its own cycle and raises no `frame_done`. It restarts loading at row 0, byte 0, after one cycle with all word lines low.
- R9: With `in_valid` held high, successive frames begin every 576 cycles: 512 write cycles plus one dead cycle per row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Abort the current frame and restart at row 0, byte 0 |
| in_valid | input | 1 | Stream byte is valid |
| in_data | input | 8 | Stream byte, bit 0 goes to the lowest column of its lane |
| in_ready | output | 1 | Controller can take a byte this cycle |
| word_line | output | 64 | Per-row write enable, bit r selects row r |
| frame_done | output | 1 | One-cycle pulse after the last byte of a frame |
| pixels | output | 4096 | Stored pixel state, bit r*64+c is row r, column c |

## Verification
The hardest states to reach from the ports are the ones where the write position is disturbed in mid-row. These are a restart pulse after twenty bytes, which leaves row 2 partly written, and a reset in the middle of a frame. In both cases the rows not yet reached must keep the previous frame's data while the position snaps back to the first byte. The stimulus drives whole frames with distinct byte patterns to fill every row, then issues the abort or reset at a counted byte. It then compares the complete pixel vector against a model in which only the rewritten bytes have changed. The 576-cycle frame period is measured by the gap between the first accepted byte of two back-to-back frames.

// File: rtl/pixwr_pkg.sv
package pixwr_pkg;
  // phase of the row-page sequencer
  typedef enum logic {
    PH_GAP  = 1'b0,   // word lines low, stream stalled
    PH_LOAD = 1'b1    // one word line high, bytes being written
  } phase_e;
endpackage

// File: rtl/onehot_dec.sv
module onehot_dec #(
  parameter int N     = 8,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [IDX_W-1:0] idx,
  input  logic             en,
  output logic [N-1:0]     sel
);
  for (genvar i = 0; i < N; i++) begin : g_dec
    assign sel[i] = en && (idx == IDX_W'(i));
  end
endmodule

// File: rtl/rowpage_seq.sv
module rowpage_seq
  import pixwr_pkg::*;
#(
  parameter int ROWS  = 64,
  parameter int LANES = 8,
  parameter int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1,
  parameter int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              wr_go,
  output logic              row_active,
  output logic [ROW_W-1:0]  row_idx,
  output logic [LANE_W-1:0] lane_idx,
  output logic              frame_done
);
  localparam logic [ROW_W-1:0]  ROW_LAST  = ROW_W'(ROWS - 1);
  localparam logic [LANE_W-1:0] LANE_LAST = LANE_W'(LANES - 1);

  phase_e             phase_q, phase_d;
  logic [ROW_W-1:0]   row_q, row_d;
  logic [LANE_W-1:0]  lane_q, lane_d;
  logic               done_q, done_d;

  assign in_ready   = (phase_q == PH_LOAD) && !frame_start;
  assign wr_go      = in_valid && in_ready;
  assign row_active = (phase_q == PH_LOAD);
  assign row_idx    = row_q;
  assign lane_idx   = lane_q;
  assign frame_done = done_q;

  // next-state logic
  always_comb begin
    phase_d = phase_q;
    row_d   = row_q;
    lane_d  = lane_q;
    done_d  = 1'b0;
    if (frame_start) begin
      phase_d = PH_GAP;
      row_d   = '0;
      lane_d  = '0;
    end else if (phase_q == PH_GAP) begin
      phase_d = PH_LOAD;
    end else if (wr_go) begin
      if (lane_q == LANE_LAST) begin
        lane_d  = '0;
        phase_d = PH_GAP;
        if (row_q == ROW_LAST) begin
          row_d  = '0;
          done_d = 1'b1;
        end else begin
          row_d = row_q + 1'b1;
        end
      end else begin
        lane_d = lane_q + 1'b1;
      end
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_GAP;
      row_q   <= '0;
      lane_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      row_q   <= row_d;
      lane_q  <= lane_d;
      done_q  <= done_d;
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  // R8
  restart_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (row_q == '0 && lane_q == '0 && !in_ready && !frame_done));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_LOAD && !in_valid && !frame_start)
      |=> ($stable(row_q) && $stable(lane_q)));

  // R3
  lane_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && lane_q != LANE_LAST) |=> (lane_q == $past(lane_q) + 1'b1));
endmodule

// File: rtl/pixel_row.sv
module pixel_row #(
  parameter int LANES  = 8,
  parameter int BYTE_W = 8,
  parameter int COLS   = LANES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              row_sel,
  input  logic [LANES-1:0]  lane_we,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [COLS-1:0]   cells
);
  // storage cells carry no reset: they hold the last value written
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic lane_en;
    assign lane_en = row_sel && lane_we[l];
    always_ff @(posedge clk) begin
      if (lane_en) begin
        cells[l*BYTE_W +: BYTE_W] <= wr_data;
      end
    end
  end

  // R6
  row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !row_sel |=> $stable(cells));
endmodule

// File: rtl/pixel_page_writer.sv
module pixel_page_writer #(
  parameter int ROWS   = 64,
  parameter int COLS   = 64,
  parameter int BYTE_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_start,
  input  logic                 in_valid,
  input  logic [BYTE_W-1:0]    in_data,
  output logic                 in_ready,
  output logic [ROWS-1:0]      word_line,
  output logic                 frame_done,
  output logic [ROWS*COLS-1:0] pixels
);
  localparam int LANES  = COLS / BYTE_W;
  localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;

  logic              wr_go;
  logic              row_active;
  logic [ROW_W-1:0]  row_idx;
  logic [LANE_W-1:0] lane_idx;
  logic [LANES-1:0]  lane_we;

  rowpage_seq #(.ROWS(ROWS), .LANES(LANES), .ROW_W(ROW_W), .LANE_W(LANE_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .wr_go       (wr_go),
    .row_active  (row_active),
    .row_idx     (row_idx),
    .lane_idx    (lane_idx),
    .frame_done  (frame_done)
  );

  onehot_dec #(.N(ROWS), .IDX_W(ROW_W)) u_row_dec (
    .idx (row_idx),
    .en  (row_active),
    .sel (word_line)
  );

  onehot_dec #(.N(LANES), .IDX_W(LANE_W)) u_lane_dec (
    .idx (lane_idx),
    .en  (wr_go),
    .sel (lane_we)
  );

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    pixel_row #(.LANES(LANES), .BYTE_W(BYTE_W), .COLS(COLS)) u_row (
      .clk     (clk),
      .rst_n   (rst_n),
      .row_sel (word_line[r]),
      .lane_we (lane_we),
      .wr_data (in_data),
      .cells   (pixels[r*COLS +: COLS])
    );
  end

  // R4
  wl_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(word_line));

  // R5
  gap_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !frame_start) |-> (word_line == '0));

  // R4
  wl_page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !(in_valid && lane_idx == LANE_W'(LANES - 1)))
      |=> (frame_start || word_line == $past(word_line)));
endmodule

// File: tb/tb_pixel_page_writer.sv
module tb_pixel_page_writer;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS = 64;
  localparam int COLS = 64;
  localparam int NBYTES = ROWS * COLS / 8;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic frame_start = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready;
  logic [ROWS-1:0] word_line;
  logic frame_done;
  logic [ROWS*COLS-1:0] pixels;

  pixel_page_writer dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .word_line(word_line), .frame_done(frame_done), .pixels(pixels)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0;
  int bad = 0;
  int nx_idx = 0;
  int done_cnt = 0;
  bit done_due = 1'b0;
  bit mon_on = 1'b0;
  logic [16:0] sb_q[$];
  logic [ROWS*COLS-1:0] exp_pix;

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int i, input int seed);
    return 8'((i * seed + (i >> 3)) ^ seed);
  endfunction

  // driver: offers one byte until taken, then pushes the expected item
  task automatic send_byte(input logic [7:0] d, output longint t_acc);
    bit acc;
    acc = 1'b0;
    while (!acc) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = d;
      #1;
      acc = in_ready;
      @(posedge clk);
    end
    t_acc = $time / CLK_PERIOD;
    sb_q.push_back({9'(nx_idx), d});
    exp_pix[nx_idx*8 +: 8] = d;
    nx_idx++;
    if (nx_idx == NBYTES) begin
      nx_idx = 0;
      done_due = 1'b1;
    end
    #1;
    in_valid = 1'b0;
  endtask

  task automatic send_frame(input int seed, input int first, input int count, input int idle_every);
    longint t;
    for (int i = first; i < first + count; i++) begin
      send_byte(pat(i, seed), t);
      if (idle_every > 0 && (i % idle_every) == 0) begin
        @(negedge clk);
        in_data = 8'hFF;
      end
    end
  endtask

  // monitor: pops scoreboard items and checks the stream-side outputs
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (mon_on) begin
        while (sb_q.size() > 0) begin
          logic [16:0] it;
          int k;
          it = sb_q.pop_front();
          k = int'(it[16:8]);
          chk(pixels[k*8 +: 8] == it[7:0], "R2 stored byte", 64'(pixels[k*8 +: 8]), 64'(it[7:0]));
        end
        chk(frame_done == done_due, "R7 done timing", 64'(frame_done), 64'(done_due));
        if (frame_done) done_cnt++;
        done_due = 1'b0;
        if (!in_ready && !frame_start)
          chk(word_line == '0, "R5 gap word lines", word_line, 64'd0);
        if (in_ready)
          chk(word_line == (64'd1 << (nx_idx / 8)), "R4 active row line", word_line, 64'd1 << (nx_idx / 8));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    longint ta, tb, tlast;
    logic [ROWS*COLS-1:0] snap;
    exp_pix = '0;
    #1 rst_n = 1'b0;
    #3;
    // R1 reset state
    chk(word_line == '0, "R1 reset word lines", word_line, 64'd0);
    chk(!in_ready, "R1 reset ready", 64'(in_ready), 64'd0);
    chk(!frame_done, "R1 reset done", 64'(frame_done), 64'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(!in_ready, "R1 dead cycle after reset", 64'(in_ready), 64'd0);
    @(negedge clk);
    #1;
    chk(in_ready && word_line == 64'd1, "R1 row 0 first", word_line, 64'd1);
    mon_on = 1'b1;

    // frame A, continuous
    send_byte(pat(0, 37), ta);
    for (int i = 1; i < NBYTES; i++) begin
      send_byte(pat(i, 37), tlast);
    end
    chk(tlast - ta == 574, "R9 last byte offset", 64'(tlast - ta), 64'd574);
    // frame B starts back to back
    send_byte(pat(0, 91), tb);
    chk(tb - ta == 576, "R9 frame period", 64'(tb - ta), 64'd576);
    chk(done_cnt == 1, "R7 one done per frame", 64'(done_cnt), 64'd1);

    // R3 idle cycles with garbage data store nothing
    snap = pixels;
    in_data = 8'hA5;
    repeat (5) @(negedge clk);
    chk(pixels == snap, "R3 idle no write", 64'(pixels[63:0]), 64'(snap[63:0]));

    // rest of frame B with idle gaps
    send_frame(91, 1, NBYTES - 1, 3);
    repeat (2) @(negedge clk);
    chk(pixels == exp_pix, "R2 full frame B", 64'(pixels[127:64]), 64'(exp_pix[127:64]));
    chk(done_cnt == 2, "R7 done after frame B", 64'(done_cnt), 64'd2);

    // frame C partial then abort
    send_frame(53, 0, 20, 0);
    @(negedge clk);
    frame_start = 1'b1;
    #1;
    chk(!in_ready, "R8 no byte in start cycle", 64'(in_ready), 64'd0);
    @(posedge clk);
    #1;
    frame_start = 1'b0;
    nx_idx = 0;
    repeat (3) @(negedge clk);
    chk(done_cnt == 2, "R8 no done on abort", 64'(done_cnt), 64'd2);
    chk(pixels[ROWS*COLS-1:3*COLS] == exp_pix[ROWS*COLS-1:3*COLS], "R6 unreached rows hold",
        64'(pixels[3*COLS +: 64]), 64'(exp_pix[3*COLS +: 64]));
    chk(pixels == exp_pix, "R6 all rows after abort", 64'(pixels[2*COLS +: 64]), 64'(exp_pix[2*COLS +: 64]));

    send_frame(77, 0, 12, 0);
    @(negedge clk);
    chk(pixels[15:0] == {pat(1, 77), pat(0, 77)}, "R8 restart at row 0",
        64'(pixels[15:0]), 64'({pat(1, 77), pat(0, 77)}));

    // reset mid frame
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    nx_idx = 0;
    chk(word_line == '0 && !in_ready, "R1 mid-frame reset", word_line, 64'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    chk(pixels == exp_pix, "R6 cells kept over reset", 64'(pixels[63:0]), 64'(exp_pix[63:0]));

    // frame D full
    send_frame(19, 0, NBYTES, 5);
    repeat (2) @(negedge clk);
    chk(pixels == exp_pix, "R2 full frame D", 64'(pixels[4095:4032]), 64'(exp_pix[4095:4032]));
    chk(done_cnt == 3, "R7 done after frame D", 64'(done_cnt), 64'd3);
    chk(sb_q.size() == 0, "R3 scoreboard drained", 64'(sb_q.size()), 64'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule